// File: doc/BRIEF.md
# SDRAM Command Decoder with Bank State Tracking

This block sits on the device side of a single-data-rate SDRAM interface. On every rising clock edge it captures the clock-enable, select, strobe, bank and address pins into one register stage. From that captured set it decodes exactly one command, and it presents the command together with its bank, row, column and auto-precharge fields.

Alongside the decode it keeps a table of four banks. The table records whether each bank has a row open and, if so, which row. Three protocol faults are reported as one-cycle pulses, each on its own output:
- a read or write aimed at a bank with no open row;
- an activate aimed at a bank whose row is still open;
- an auto refresh issued while any bank is open.

A faulty command is still reported on the command output, but it leaves the bank table untouched. Power-down, self refresh, burst timing and the storage array all belong to other blocks.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: Pins are captured on the rising clock edge. The decoded command and its fields are valid from just after that edge until the next one, with no further delay. Bank-table changes caused by a command become visible one edge later.
- R2: A captured low clock enable decodes as NOP (code 1), whatever the other pins are. Otherwise a captured high select decodes as INHIBIT (code 0). Neither one changes any bank state.
- R3: With clock enable high and select low, the strobes {RAS#, CAS#, WE#} decode as follows:
  - 111 is NOP (1)
  - 011 is ACTIVATE (2)
  - 101 is READ (3)
  - 100 is WRITE (4)
  - 110 is BURST STOP (5)
  - 010 is PRECHARGE (6)
  - 001 is REFRESH (7)
  - 000 is MODE LOAD (8)
- R4: An ACTIVATE to an idle bank marks that bank open and stores A[12:0] as its open row. The row is stored in the per-bank field at bits [13*b+12 : 13*b].
- R5: The bank output always carries BA and the row output carries A[12:0]. The column output carries A[8:0]. The auto-precharge output equals A10 during READ or WRITE and is 0 for every other command. An accepted READ or WRITE with A10 high closes its bank.
- R6: A PRECHARGE with A10 low closes only the bank on BA. A PRECHARGE with A10 high closes all four banks.
- R7: A READ or WRITE to an idle bank pulses `err_idle_access` for that cycle, and the bank table is left unchanged.
- R8: An ACTIVATE to an open bank pulses `err_double_act`. The bank stays open with its earlier row.
- R9: A REFRESH with any bank open pulses `err_refresh_open`. A REFRESH with all banks idle raises no error and changes nothing.
- R10: Reset leaves every bank idle, every stored row at 0 and the command output at INHIBIT.
- R11: An ACTIVATE to one idle bank is accepted while other banks are open. No bank can become open except through an accepted ACTIVATE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select pins |
| addr | input | 13 | Address pins |
| cmd | output | 4 | Decoded command code |
| cmd_bank | output | 2 | Bank of the decoded command |
| cmd_row | output | 13 | Captured A[12:0] |
| cmd_col | output | 9 | Captured A[8:0] |
| cmd_ap | output | 1 | Auto-precharge request of a READ or WRITE |
| bank_open | output | 4 | One bit per bank, high while a row is open |
| open_rows | output | 52 | Stored row of each bank, 13 bits per bank |
| err_idle_access | output | 1 | Pulse: READ or WRITE to an idle bank |
| err_double_act | output | 1 | Pulse: ACTIVATE to an open bank |
| err_refresh_open | output | 1 | Pulse: REFRESH with a bank open |

## Verification
The properties assume the pins are stable around the rising edge and are known (not X) once reset has ended. They also assume that exactly one command is decoded per cycle, so that a faulty command is the only possible source of change in that cycle. The stimulus drives every pin on the falling edge and holds it through the next rising edge. It first walks a directed sequence through each fault and each precharge form. It then sends random pin patterns in which select and clock enable are sometimes inactive, so faulty commands are mixed in with legal ones.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [3:0] {
    CMD_INHIBIT = 4'd0,
    CMD_NOP     = 4'd1,
    CMD_ACT     = 4'd2,
    CMD_RD      = 4'd3,
    CMD_WR      = 4'd4,
    CMD_BST     = 4'd5,
    CMD_PRE     = 4'd6,
    CMD_REF     = 4'd7,
    CMD_LMR     = 4'd8
  } sd_cmd_e;

  // Command decode from captured pins; clock enable dominates select.
  function automatic sd_cmd_e decode_pins(input logic cke_i, input logic cs_i,
                                          input logic ras_i, input logic cas_i,
                                          input logic we_i);
    sd_cmd_e c;
    if (!cke_i)     c = CMD_NOP;
    else if (cs_i)  c = CMD_INHIBIT;
    else begin
      case ({ras_i, cas_i, we_i})
        3'b111:  c = CMD_NOP;
        3'b011:  c = CMD_ACT;
        3'b101:  c = CMD_RD;
        3'b100:  c = CMD_WR;
        3'b110:  c = CMD_BST;
        3'b010:  c = CMD_PRE;
        3'b001:  c = CMD_REF;
        default: c = CMD_LMR;
      endcase
    end
    return c;
  endfunction

  function automatic logic is_access(input sd_cmd_e c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction

endpackage

// File: rtl/sdcmd_pin_reg.sv
module sdcmd_pin_reg #(
  parameter int BA_W   = 2,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  output logic              cke_q,
  output logic              cs_q,
  output logic              ras_q,
  output logic              cas_q,
  output logic              we_q,
  output logic [BA_W-1:0]   ba_q,
  output logic [ADDR_W-1:0] addr_q
);

  // Reset value reads as a deselected (inhibit) cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q  <= 1'b1;
      cs_q   <= 1'b1;
      ras_q  <= 1'b1;
      cas_q  <= 1'b1;
      we_q   <= 1'b1;
      ba_q   <= '0;
      addr_q <= '0;
    end else begin
      cke_q  <= cke;
      cs_q   <= cs_n;
      ras_q  <= ras_n;
      cas_q  <= cas_n;
      we_q   <= we_n;
      ba_q   <= ba;
      addr_q <= addr;
    end
  end

endmodule

// File: rtl/sdcmd_bank_table.sv
module sdcmd_bank_table
  import sdcmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2,
  parameter int ADDR_W    = 13,
  parameter int ROW_W     = 13,
  parameter int AP_BIT    = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  sd_cmd_e                    cmd,
  input  logic [BA_W-1:0]            ba,
  input  logic [ADDR_W-1:0]          addr,
  output logic [NUM_BANKS-1:0]       open_o,
  output logic [NUM_BANKS*ROW_W-1:0] rows_o,
  output logic                       err_idle,
  output logic                       err_dup,
  output logic                       err_ref,
  output logic                       act_fire,
  output logic [NUM_BANKS-1:0]       close_mask
);

  logic [NUM_BANKS-1:0] open_q;
  logic [NUM_BANKS-1:0] sel;
  logic                 sel_open;

  assign sel      = NUM_BANKS'(1) << ba;
  assign sel_open = |(open_q & sel);

  // Rule checks against the table as it stood before this command.
  assign err_idle = is_access(cmd) && !sel_open;
  assign err_dup  = (cmd == CMD_ACT) && sel_open;
  assign err_ref  = (cmd == CMD_REF) && (|open_q);
  assign act_fire = (cmd == CMD_ACT) && !sel_open;

  always_comb begin
    close_mask = '0;
    if (cmd == CMD_PRE)
      close_mask = addr[AP_BIT] ? {NUM_BANKS{1'b1}} : sel;
    else if (is_access(cmd) && sel_open && addr[AP_BIT])
      close_mask = sel;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [ROW_W-1:0] row_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q[b] <= 1'b0;
        row_q     <= '0;
      end else if (act_fire && sel[b]) begin
        open_q[b] <= 1'b1;
        row_q     <= addr[ROW_W-1:0];
      end else if (close_mask[b]) begin
        open_q[b] <= 1'b0;
      end
    end
    assign rows_o[b*ROW_W +: ROW_W] = row_q;
  end

  assign open_o = open_q;

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdcmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 9,
  parameter int AP_BIT    = 10,
  localparam int BA_W     = $clog2(NUM_BANKS),
  localparam int ADDR_W   = ROW_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cke,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [BA_W-1:0]            ba,
  input  logic [ADDR_W-1:0]          addr,
  output logic [3:0]                 cmd,
  output logic [BA_W-1:0]            cmd_bank,
  output logic [ROW_W-1:0]           cmd_row,
  output logic [COL_W-1:0]           cmd_col,
  output logic                       cmd_ap,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] open_rows,
  output logic                       err_idle_access,
  output logic                       err_double_act,
  output logic                       err_refresh_open
);

  logic              cke_q, cs_q, ras_q, cas_q, we_q;
  logic [BA_W-1:0]   ba_q;
  logic [ADDR_W-1:0] addr_q;
  sd_cmd_e           cmd_dec;
  logic              act_fire;
  logic [NUM_BANKS-1:0] close_mask;

  sdcmd_pin_reg #(.BA_W(BA_W), .ADDR_W(ADDR_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .cke_q(cke_q), .cs_q(cs_q), .ras_q(ras_q), .cas_q(cas_q), .we_q(we_q),
    .ba_q(ba_q), .addr_q(addr_q)
  );

  assign cmd_dec = decode_pins(cke_q, cs_q, ras_q, cas_q, we_q);

  sdcmd_bank_table #(
    .NUM_BANKS(NUM_BANKS), .BA_W(BA_W), .ADDR_W(ADDR_W),
    .ROW_W(ROW_W), .AP_BIT(AP_BIT)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .cmd(cmd_dec), .ba(ba_q), .addr(addr_q),
    .open_o(bank_open), .rows_o(open_rows),
    .err_idle(err_idle_access), .err_dup(err_double_act),
    .err_ref(err_refresh_open), .act_fire(act_fire), .close_mask(close_mask)
  );

  assign cmd      = cmd_dec;
  assign cmd_bank = ba_q;
  assign cmd_row  = addr_q[ROW_W-1:0];
  assign cmd_col  = addr_q[COL_W-1:0];
  assign cmd_ap   = is_access(cmd_dec) && addr_q[AP_BIT];

endmodule

// File: rtl/sdcmd_checker.sv
module sdcmd_checker
  import sdcmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int BA_W      = 2,
  parameter int AP_BIT    = 10
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [3:0]                 cmd,
  input logic [BA_W-1:0]            cmd_bank,
  input logic [ROW_W-1:0]           cmd_row,
  input logic [NUM_BANKS-1:0]       bank_open,
  input logic [NUM_BANKS*ROW_W-1:0] open_rows,
  input logic                       err_idle_access,
  input logic                       err_double_act,
  input logic                       err_refresh_open,
  input logic                       act_fire
);

  p_act_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT && !err_double_act) |=>
      bank_open[$past(cmd_bank)] &&
      open_rows[$past(cmd_bank)*ROW_W +: ROW_W] == $past(cmd_row));

  p_pre_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE && cmd_row[AP_BIT]) |=> (bank_open == '0));

  p_pre_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE && !cmd_row[AP_BIT]) |=> !bank_open[$past(cmd_bank)]);

  p_idle_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_idle_access |=> $stable(bank_open));

  p_dup_keeps_row_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_double_act |=> $stable(bank_open) && $stable(open_rows));

  p_ref_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_refresh_open |=> $stable(bank_open));

  p_one_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_idle_access, err_double_act, err_refresh_open}));

  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_INHIBIT || cmd == CMD_NOP) |=>
      $stable(bank_open) && $stable(open_rows));

  p_open_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|(bank_open & ~$past(bank_open))) |-> $past(act_fire));

endmodule

bind sdram_cmd_tracker sdcmd_checker #(
  .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .BA_W(BA_W), .AP_BIT(AP_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
  .bank_open(bank_open), .open_rows(open_rows),
  .err_idle_access(err_idle_access), .err_double_act(err_double_act),
  .err_refresh_open(err_refresh_open), .act_fire(act_fire)
);

// File: tb/sdram_cmd_tracker_test.sv
module sdram_cmd_tracker_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic [3:0]  cmd;
  logic [1:0]  cmd_bank;
  logic [12:0] cmd_row;
  logic [8:0]  cmd_col;
  logic        cmd_ap;
  logic [3:0]  bank_open;
  logic [51:0] open_rows;
  logic        err_idle_access, err_double_act, err_refresh_open;

  int n_chk = 0;
  int n_bad = 0;

  // Reference state
  bit          m_open [4];
  logic [12:0] m_row  [4];
  // strobe pattern {ras,cas,we} -> code
  int code_of [8] = '{8, 7, 6, 2, 4, 3, 5, 1};

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_tracker uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd(cmd),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_ap(cmd_ap),
    .bank_open(bank_open), .open_rows(open_rows),
    .err_idle_access(err_idle_access), .err_double_act(err_double_act),
    .err_refresh_open(err_refresh_open)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Drive one pin set, let it be captured, then compare and advance the model.
  task automatic step(input bit k, input bit s, input bit r, input bit c,
                      input bit w, input logic [1:0] b, input logic [12:0] a);
    int  code;
    bit  any, e_idle, e_dup, e_ref, acc;
    logic [3:0] exp_open;
    cke = k; cs_n = s; ras_n = r; cas_n = c; we_n = w; ba = b; addr = a;
    @(posedge clk);
    @(negedge clk);
    if (!k)      code = 1;
    else if (s)  code = 0;
    else         code = code_of[{r, c, w}];
    any = 0;
    for (int i = 0; i < 4; i++) begin
      any |= m_open[i];
      exp_open[i] = m_open[i];
    end
    acc    = (code == 3) || (code == 4);
    e_idle = acc && !m_open[b];
    e_dup  = (code == 2) && m_open[b];
    e_ref  = (code == 7) && any;
    check((code < 2) ? "R1 R2 cmd" : "R1 R3 cmd", cmd, code);
    check("R5 bank", cmd_bank, b);
    check("R5 row", cmd_row, a);
    check("R5 col", cmd_col, a[8:0]);
    check("R5 ap", cmd_ap, acc && a[10]);
    check("R7 idle access", err_idle_access, e_idle);
    check("R8 double act", err_double_act, e_dup);
    check("R9 refresh open", err_refresh_open, e_ref);
    check("R4 R6 R11 bank_open", bank_open, exp_open);
    for (int i = 0; i < 4; i++)
      check("R4 R8 open row", open_rows[i*13 +: 13], m_row[i]);
    // Apply to the model
    if (code == 2 && !e_dup) begin
      m_open[b] = 1;
      m_row[b]  = a;
    end else if (code == 6) begin
      if (a[10]) for (int i = 0; i < 4; i++) m_open[i] = 0;
      else       m_open[b] = 0;
    end else if (acc && !e_idle && a[10]) begin
      m_open[b] = 0;
    end
  endtask

  // Command helpers: pins {ras,cas,we}
  task automatic act(input logic [1:0] b, input logic [12:0] a); step(1,0,0,1,1,b,a); endtask
  task automatic rd (input logic [1:0] b, input logic [12:0] a); step(1,0,1,0,1,b,a); endtask
  task automatic wr (input logic [1:0] b, input logic [12:0] a); step(1,0,1,0,0,b,a); endtask
  task automatic pre(input logic [1:0] b, input logic [12:0] a); step(1,0,0,1,0,b,a); endtask
  task automatic rfr();                                        step(1,0,0,0,1,2'd0,13'd0); endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_row[i] = '0; end
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset cmd", cmd, 0);
    check("R10 reset bank_open", bank_open, 0);
    check("R10 reset rows", open_rows, 0);
    rst_n = 1'b1;
    step(1,1,0,1,1,2'd1,13'h0AA);      // R2 deselected activate
    step(0,0,0,1,1,2'd1,13'h0AA);      // R2 clock enable low: NOP, no open
    act(2'd0, 13'h1ABC);                // R4
    act(2'd2, 13'h0005);                // R11 second bank
    act(2'd0, 13'h0777);                // R8 duplicate
    rd (2'd1, 13'h0010);                // R7 idle bank read
    wr (2'd3, 13'h0410);                // R7 idle bank write with ap
    rd (2'd0, 13'h01FF);                // R5 column, no ap
    wr (2'd2, 13'h0403);                // R5 ap closes bank 2
    rfr();                              // R9 bank 0 open
    step(1,0,1,1,0,2'd0,13'h0);        // R3 burst stop
    step(1,0,0,0,0,2'd0,13'h0032);     // R3 mode load
    step(1,0,1,1,1,2'd0,13'h0);        // R3 NOP
    pre(2'd0, 13'h0000);                // R6 single bank
    act(2'd1, 13'h1FFF);
    act(2'd3, 13'h0001);
    pre(2'd2, 13'h0400);                // R6 all banks
    rfr();                              // R9 legal refresh
    act(2'd3, 13'h0100);
    rd (2'd3, 13'h0000);
    for (int n = 0; n < 600; n++) begin
      step(($urandom % 10) != 0, ($urandom % 8) == 0, 1'($urandom), 1'($urandom),
           1'($urandom), 2'($urandom), 13'($urandom));
    end
    summary();
  end

endmodule